// File: doc/BRIEF.md
# SDRAM burst column address generator

This block produces the column address sequence for a single read or write burst of a double data rate SDRAM. The command logic gives it a start pulse together with the starting column, a burst length code and a burst order. Because the array is read and written two beats at a time, the generator steps two beats per clock. On each handshake it emits one column pair: the even beat and the odd beat of the burst.

Column pairs leave on a valid/ready stream. A pair is transferred on every clock edge where `pair_valid` and `pair_ready` are both high. While `pair_valid` is high and `pair_ready` is low, the pair is held unchanged. It stays held until it is accepted, a stop request arrives, or a new legal start arrives. The generator never withdraws a pair for any other reason. `pair_ready` may change freely at any time. Fixed-length bursts end by themselves after the final pair. A full-page burst runs until a stop request or a new start. An illegal full-page request is refused with a one-cycle error pulse.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Length code `bl_code` selects the burst length: 0 = 2 beats, 1 = 4, 2 = 8, 3 = full page (256 columns). `burst_order` 0 = sequential, 1 = interleaved. On the edge after a legal start, `pair_valid` is high and the pair shown holds beats 0 and 1.
- R2: In sequential order, beat k is at column {upper bits of start, (low bits of start + k) mod BL}. The low log2(BL) bits wrap inside the aligned block and the upper bits never change.
- R3: In interleaved order, beat k is at column start XOR k. The XOR acts only on the low log2(BL) bits.
- R4: Each pair carries beat 2p on `pair_col_a` and beat 2p+1 on `pair_col_b`. In a fixed-length burst, `pair_last` is high only on pair BL/2-1. After that pair is accepted, `pair_valid` is low on the next cycle.
- R5: While `pair_valid` is high and `pair_ready` is low (no start, no stop), the next cycle still shows the same pair with `pair_valid` high.
- R6: A full-page burst steps through consecutive columns, wrapping from 255 to 0. It never raises `pair_last`.
- R7: `burst_stop` high without `burst_start` makes `pair_valid` low on the next cycle.
- R8: A full-page request with interleaved order, or with an odd start column, raises `cfg_err` for exactly one cycle after the start. It starts no burst, and any running burst continues unchanged.
- R9: A legal start while a burst runs discards that burst and begins the new one on the next cycle. A legal start wins over a simultaneous `burst_stop`.
- R10: During and right after reset, `pair_valid`, `pair_last` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | One-cycle request to begin a burst |
| start_col | input | 8 | Starting column of the burst |
| bl_code | input | 2 | Burst length code (R1) |
| burst_order | input | 1 | 0 sequential, 1 interleaved |
| burst_stop | input | 1 | Terminates the running burst |
| pair_valid | output | 1 | Column pair available |
| pair_ready | input | 1 | Consumer accepts the pair |
| pair_col_a | output | 8 | Column of the even beat |
| pair_col_b | output | 8 | Column of the odd beat |
| pair_last | output | 1 | Final pair of a fixed-length burst |
| cfg_err | output | 1 | One-cycle pulse on an illegal full-page request |

## Verification
The assertions assume that `burst_start` and `burst_stop` are sampled only at rising edges. They also assume that the start column, length code and order are steady in the cycle where `burst_start` is high. The hold property exempts cycles with a start or a stop, since those may replace or drop the pair. The bench drives every input on the falling edge and pulses start for exactly one cycle. It lowers `pair_ready` only in the back-pressure and illegal-request cases, so every other check meets a known handshake pattern.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int BL_CODE_W = 2;

  typedef enum logic [BL_CODE_W-1:0] {
    BL_TWO   = 2'd0,
    BL_FOUR  = 2'd1,
    BL_EIGHT = 2'd2,
    BL_PAGE  = 2'd3
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [BL_CODE_W-1:0] bl_code,
  input  logic                 order_ilv,
  input  logic [COL_W-1:0]     start_col,
  output logic [COL_W-1:0]     wrap_mask,
  output logic                 is_page,
  output logic                 is_legal
);
  blen_e blen;

  always_comb begin
    blen    = blen_e'(bl_code);
    is_page = (blen == BL_PAGE);
    case (blen)
      BL_TWO:   wrap_mask = COL_W'(1);
      BL_FOUR:  wrap_mask = COL_W'(3);
      BL_EIGHT: wrap_mask = COL_W'(7);
      default:  wrap_mask = '1;
    endcase
    // full page only sequential and from an even column
    is_legal = !is_page || (!order_ilv && !start_col[0]);
  end
endmodule

// File: rtl/burst_beat_index.sv
module burst_beat_index #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             is_page,
  output logic [COL_W-1:0] beat_k,
  output logic             final_pair
);
  localparam logic [COL_W-1:0] STEP = COL_W'(2);
  localparam logic [COL_W-1:0] ODD  = COL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       beat_k <= '0;
    else if (load)    beat_k <= '0;
    else if (advance) beat_k <= beat_k + STEP;
  end

  assign final_pair = !is_page && ((beat_k | ODD) == wrap_mask);

  a_r4_even_index: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (beat_k[0] == 1'b0));
endmodule

// File: rtl/burst_col_lane.sv
module burst_col_lane #(
  parameter int COL_W = 8,
  parameter int LANE  = 0
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             order_ilv,
  input  logic [COL_W-1:0] beat_k,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] LANE_OFS = COL_W'(LANE);
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] sum;

  always_comb begin
    beat = beat_k | LANE_OFS;
    sum  = base_col + beat;
    if (order_ilv) col = base_col ^ beat;
    else           col = (base_col & ~wrap_mask) | (sum & wrap_mask);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  input  logic             burst_order,
  input  logic             burst_stop,
  output logic             pair_valid,
  input  logic             pair_ready,
  output logic [COL_W-1:0] pair_col_a,
  output logic [COL_W-1:0] pair_col_b,
  output logic             pair_last,
  output logic             cfg_err
);
  localparam int LANES = 2;

  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_legal;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             page_q;
  logic             valid_q;
  logic             err_q;
  logic [COL_W-1:0] beat_k;
  logic             final_pair;
  logic             start_ok;
  logic             accept;
  logic [COL_W-1:0] lane_col [LANES];

  burst_cfg_decode #(.COL_W(COL_W)) u_decode (
    .bl_code   (bl_code),
    .order_ilv (burst_order),
    .start_col (start_col),
    .wrap_mask (dec_mask),
    .is_page   (dec_page),
    .is_legal  (dec_legal)
  );

  assign start_ok = burst_start && dec_legal;
  assign accept   = valid_q && pair_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
    end else begin
      err_q <= burst_start && !dec_legal;
      if (start_ok) begin
        valid_q <= 1'b1;
        base_q  <= start_col;
        mask_q  <= dec_mask;
        ilv_q   <= burst_order;
        page_q  <= dec_page;
      end else if (burst_stop) begin
        valid_q <= 1'b0;
      end else if (accept && final_pair) begin
        valid_q <= 1'b0;
      end
    end
  end

  burst_beat_index #(.COL_W(COL_W)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_ok),
    .advance    (accept),
    .wrap_mask  (mask_q),
    .is_page    (page_q),
    .beat_k     (beat_k),
    .final_pair (final_pair)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    burst_col_lane #(.COL_W(COL_W), .LANE(g)) u_lane (
      .base_col  (base_q),
      .wrap_mask (mask_q),
      .order_ilv (ilv_q),
      .beat_k    (beat_k),
      .col       (lane_col[g])
    );
  end

  assign pair_valid = valid_q;
  assign pair_col_a = lane_col[0];
  assign pair_col_b = lane_col[1];
  assign pair_last  = valid_q && final_pair;
  assign cfg_err    = err_q;

  a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> pair_valid);

  a_r2_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (((pair_col_a ^ base_q) & ~mask_q) == '0) &&
                   (((pair_col_b ^ base_q) & ~mask_q) == '0));

  a_r4_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last |-> pair_valid);

  a_r4_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last && pair_ready && !burst_start |=> !pair_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready && !burst_start && !burst_stop
      |=> pair_valid && $stable(pair_col_a) && $stable(pair_col_b));

  a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && page_q |-> !pair_last);

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop && !burst_start |=> !pair_valid);

  a_r8_refused: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start && !dec_legal && !pair_valid |=> cfg_err && !pair_valid);

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !burst_start |=> !cfg_err);
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       burst_start;
  logic [7:0] start_col;
  logic [1:0] bl_code;
  logic       burst_order;
  logic       burst_stop;
  logic       pair_valid;
  logic       pair_ready;
  logic [7:0] pair_col_a;
  logic [7:0] pair_col_b;
  logic       pair_last;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .start_col(start_col),
    .bl_code(bl_code), .burst_order(burst_order), .burst_stop(burst_stop),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_col_a(pair_col_a),
    .pair_col_b(pair_col_b), .pair_last(pair_last), .cfg_err(cfg_err)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen_of(int blc);
    return (blc == 3) ? 256 : (2 << blc);
  endfunction

  function automatic int exp_col(int s, int blc, bit ilv, int k);
    int n = blen_of(blc);
    if (ilv) return (s ^ k) & 255;
    return (s - (s % n)) + (((s % n) + k) % n);
  endfunction

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // caller is at a falling edge; returns one cycle after the start edge
  task automatic issue(int s, int blc, bit ilv);
    burst_start = 1; start_col = 8'(s); bl_code = 2'(blc); burst_order = ilv;
    @(negedge clk);
    burst_start = 0;
  endtask

  // ready is high; checks pairs first..first+n-1, one per cycle
  task automatic check_pairs(int s, int blc, bit ilv, int first, int n, string req);
    for (int p = first; p < first + n; p++) begin
      bit lst = (blc != 3) && (2 * p + 2 == blen_of(blc));
      chk(pair_valid == 1, req, pair_valid, 1);
      chk(pair_col_a == exp_col(s, blc, ilv, 2 * p), req, pair_col_a, exp_col(s, blc, ilv, 2 * p));
      chk(pair_col_b == exp_col(s, blc, ilv, 2 * p + 1), req, pair_col_b, exp_col(s, blc, ilv, 2 * p + 1));
      chk(pair_last == lst, "R4 last flag", pair_last, lst);
      @(negedge clk);
    end
  endtask

  task automatic t_fixed(int s, int blc, bit ilv, string req);
    issue(s, blc, ilv);
    check_pairs(s, blc, ilv, 0, blen_of(blc) / 2, req);
    chk(pair_valid == 0, "R4 end after last", pair_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_backpressure;
    issue(8'h40, 2, 0);
    pair_ready = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(pair_valid == 1, "R5 hold valid", pair_valid, 1);
      chk(pair_col_a == 8'h40 && pair_col_b == 8'h41, "R5 hold pair", pair_col_a, 8'h40);
    end
    pair_ready = 1;
    check_pairs(8'h40, 2, 0, 0, 4, "R5 resume");
    chk(pair_valid == 0, "R5 end", pair_valid, 0);
  endtask

  task automatic t_page_stop;
    issue(8'hFC, 3, 0);
    check_pairs(8'hFC, 3, 0, 0, 4, "R6 page wrap");
    burst_stop = 1;
    @(negedge clk);
    burst_stop = 0;
    chk(pair_valid == 0, "R7 stop", pair_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_illegal(int s, bit ilv, string req);
    issue(s, 3, ilv);
    chk(cfg_err == 1, req, cfg_err, 1);
    chk(pair_valid == 0, "R8 no burst", pair_valid, 0);
    @(negedge clk);
    chk(cfg_err == 0, "R8 single pulse", cfg_err, 0);
  endtask

  task automatic t_illegal_busy;
    issue(8'h20, 2, 0);
    check_pairs(8'h20, 2, 0, 0, 1, "R8 first pair");
    pair_ready = 0;
    issue(8'h31, 3, 0);
    pair_ready = 1;
    chk(cfg_err == 1, "R8 err while busy", cfg_err, 1);
    check_pairs(8'h20, 2, 0, 1, 3, "R8 burst continues");
    chk(pair_valid == 0, "R8 burst end", pair_valid, 0);
  endtask

  task automatic t_restart;
    issue(8'h80, 2, 0);
    check_pairs(8'h80, 2, 0, 0, 1, "R9 first burst");
    burst_stop = 1;
    issue(8'h91, 1, 0);
    burst_stop = 0;
    check_pairs(8'h91, 1, 0, 0, 2, "R9 restart");
    chk(pair_valid == 0, "R9 end", pair_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; burst_start = 0; start_col = 0; bl_code = 0;
    burst_order = 0; burst_stop = 0; pair_ready = 1;
    repeat (3) @(negedge clk);
    chk(pair_valid == 0, "R10 valid in reset", pair_valid, 0);
    chk(pair_last == 0, "R10 last in reset", pair_last, 0);
    chk(cfg_err == 0, "R10 err in reset", cfg_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pair_valid == 0, "R10 idle after reset", pair_valid, 0);
    t_fixed(8'h37, 0, 0, "R1 R2 seq two");
    t_fixed(8'h05, 1, 0, "R2 seq four");
    t_fixed(8'h1B, 2, 0, "R2 seq eight");
    t_fixed(8'h1B, 2, 1, "R3 ilv eight");
    t_fixed(8'h06, 1, 1, "R3 ilv four");
    t_backpressure();
    t_page_stop();
    t_illegal(8'h10, 1, "R8 page interleaved");
    t_illegal(8'h11, 0, "R8 page odd start");
    t_illegal_busy();
    t_restart();
    done = 1;
    report();
    $finish;
  end
endmodule